// File: doc/BRIEF.md
# Byte-Accessed Modulo Timer Counter

A 16-bit up-counter that steps once for every cycle a single-cycle timer tick is high, and returns to zero on the tick that finds it equal to a programmable 16-bit limit. That wrap sets a sticky overflow flag. When enabled, the flag drives an interrupt output. Software reaches the block through an 8-bit register bus with a combinational read path. Read strobes and write strobes take effect at the clock edge that ends the access.

Because the bus is one byte wide, two mechanisms keep 16-bit values coherent. Reading the upper count byte freezes a copy of the lower byte, so the byte pair always describes one instant. Writing the upper limit byte suspends overflow reporting until the lower limit byte arrives, so a half-updated limit cannot produce a false overflow. A debug-freeze input stops counting. A self-clearing control bit zeroes the counter.

Register offsets: 0x20 control/status, 0x21 count upper byte, 0x22 count lower byte, 0x23 limit upper byte, 0x24 limit lower byte. In the control/status byte:
- bit 7 is the overflow flag. Writing 0 clears it and writing 1 leaves it as it is.
- bit 6 is the interrupt enable.
- bit 5 is the counter-clear command. It always reads 0.
- the other bits read 0.

Top module: `bmt_top`

## Requirements
- R1: After reset the count is 0x0000, the limit is 0xFFFF, the control/status byte reads 0x00 and the interrupt output is low.
- R2: On each clock edge where the tick input is 1 and freeze is 0, the count rises by one when it differs from the limit. The new value is visible the cycle after the tick.
- R3: On a tick where the count equals the limit, the count becomes 0x0000 and the overflow flag (bit 7 of 0x20) becomes 1 at the same edge.
- R4: Reading 0x21 returns the live upper count byte. Reading 0x22 with no latched byte held returns the live lower byte.
- R5: Reading 0x21 with no latched byte held captures the lower count byte. The next read of 0x22 returns that captured byte and releases the latch.
- R6: Further reads of 0x21 while a captured byte is held leave the captured byte unchanged. Only a read of 0x22 releases it.
- R7: Writes to 0x21 and 0x22 have no effect on the count or on the read latch.
- R8: After a write to 0x23, wraps still return the count to zero but do not set the flag, and the interrupt output stays low. This lasts until 0x24 is written.
- R9: Writing 1 to bit 5 of 0x20 zeroes the count at the next edge, with priority over a tick. The bit reads back 0. The limit and any captured lower byte are unchanged.
- R10: Writing 0x20 with bit 7 = 0 clears the flag. Writing it with bit 7 = 1 leaves the flag unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R11: The interrupt output is high exactly when the flag is 1, the enable (bit 6 of 0x20) is 1, and no limit write is pending.
- R12: While freeze is 1, ticks do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Single-cycle timer tick |
| freeze | input | 1 | Debug freeze; holds the count |
| bus_addr | input | 8 | Register offset |
| bus_rd | input | 1 | Read strobe (side effects at the edge) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
Read data is due in the same cycle as the read strobe. The bench samples it one delay step after driving the address, before the edge that carries the read's side effect. A tick, a register write or a counter clear shows its result from the first edge after the strobe. The bench advances its arithmetic model at that same edge and checks one step later. The interrupt output follows the flag, enable and pending-write state without added delay, so it is checked in the cycle right after the write or wrap that changes it. Limits 0 through 12 are swept across two full periods each, and every tick is compared.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;
    localparam int N_LANES = 2;
    localparam int CNT_W = N_LANES * BYTE_W;

    localparam int CTL_FLAG_BIT = 7;
    localparam int CTL_IEN_BIT  = 6;
    localparam int CTL_CLR_BIT  = 5;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CNT_HI,
        SEL_CNT_LO,
        SEL_MOD_HI,
        SEL_MOD_LO
    } reg_sel_e;

    typedef struct packed {
        logic rd_cnt_hi;
        logic rd_cnt_lo;
        logic wr_ctrl;
        logic wr_mod_hi;
        logic wr_mod_lo;
    } strobe_t;

    typedef struct packed {
        logic flag_keep;
        logic irq_en;
        logic cnt_clear;
    } ctrl_wr_t;

    function automatic ctrl_wr_t unpack_ctrl(input byte_t d);
        ctrl_wr_t c;
        c.flag_keep = d[CTL_FLAG_BIT];
        c.irq_en    = d[CTL_IEN_BIT];
        c.cnt_clear = d[CTL_CLR_BIT];
        return c;
    endfunction

    function automatic byte_t pack_status(input logic flag, input logic ien);
        byte_t s;
        s = '0;
        s[CTL_FLAG_BIT] = flag;
        s[CTL_IEN_BIT]  = ien;
        return s;
    endfunction

    function automatic cnt_t next_count(input cnt_t cur, input cnt_t lim);
        return (cur == lim) ? '0 : cur + cnt_t'(1);
    endfunction
endpackage

// File: rtl/bmt_regdec.sv
module bmt_regdec
    import bmt_pkg::*;
#(
    parameter addr_t A_CTRL   = 8'h20,
    parameter addr_t A_CNT_HI = 8'h21,
    parameter addr_t A_CNT_LO = 8'h22,
    parameter addr_t A_MOD_HI = 8'h23,
    parameter addr_t A_MOD_LO = 8'h24
) (
    input  addr_t    addr,
    input  logic     rd,
    input  logic     wr,
    output reg_sel_e sel,
    output strobe_t  stb
);
    always_comb begin
        if (addr == A_CTRL)        sel = SEL_CTRL;
        else if (addr == A_CNT_HI) sel = SEL_CNT_HI;
        else if (addr == A_CNT_LO) sel = SEL_CNT_LO;
        else if (addr == A_MOD_HI) sel = SEL_MOD_HI;
        else if (addr == A_MOD_LO) sel = SEL_MOD_LO;
        else                       sel = SEL_NONE;
    end

    // Count bytes have no write strobe at all: writes there fall away here.
    always_comb begin
        stb.rd_cnt_hi = rd && (sel == SEL_CNT_HI);
        stb.rd_cnt_lo = rd && (sel == SEL_CNT_LO);
        stb.wr_ctrl   = wr && (sel == SEL_CTRL);
        stb.wr_mod_hi = wr && (sel == SEL_MOD_HI);
        stb.wr_mod_lo = wr && (sel == SEL_MOD_LO);
    end
endmodule

// File: rtl/bmt_counter.sv
module bmt_counter
    import bmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic freeze,
    input  logic clr,
    input  cnt_t limit,
    output cnt_t count,
    output logic wrap_evt
);
    logic adv;

    assign adv      = tick && !freeze && !clr;
    assign wrap_evt = adv && (count == limit);

    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (clr) count <= '0;
        else if (adv) count <= next_count(count, limit);
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !freeze && !clr && count != limit) |=> (count == $past(count) + cnt_t'(1)));

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !freeze && count == limit) |=> (count == '0));

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

    p_freeze_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (freeze && !clr) |=> $stable(count));
endmodule

// File: rtl/bmt_rdlatch.sv
module bmt_rdlatch
    import bmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_hi,
    input  logic  rd_lo,
    input  byte_t live_lo,
    output byte_t lo_view
);
    logic  held;
    byte_t snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            snap <= '0;
        end else if (rd_lo) begin
            held <= 1'b0;
        end else if (rd_hi && !held) begin
            held <= 1'b1;
            snap <= live_lo;
        end
    end

    assign lo_view = held ? snap : live_lo;

    p_snap_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (held && !rd_lo) |=> (held && $stable(snap)));

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> !held);

    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_hi && !held) |=> (held && snap == $past(live_lo)));
endmodule

// File: rtl/bmt_ovf.sv
module bmt_ovf
    import bmt_pkg::*;
#(
    parameter cnt_t LIMIT_RST = '1
) (
    input  logic    clk,
    input  logic    rst,
    input  strobe_t stb,
    input  byte_t   wdata,
    input  logic    wrap_evt,
    output cnt_t    limit,
    output logic    flag,
    output logic    ien,
    output logic    pending,
    output logic    cnt_clr,
    output logic    irq
);
    ctrl_wr_t cw;
    logic     flag_clr;
    byte_t    lane_q [N_LANES];
    logic     lane_we [N_LANES];

    assign cw       = unpack_ctrl(wdata);
    assign cnt_clr  = stb.wr_ctrl && cw.cnt_clear;
    assign flag_clr = stb.wr_ctrl && !cw.flag_keep;

    assign lane_we[0] = stb.wr_mod_lo;
    assign lane_we[1] = stb.wr_mod_hi;

    for (genvar b = 0; b < N_LANES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)             lane_q[b] <= LIMIT_RST[b*BYTE_W +: BYTE_W];
            else if (lane_we[b]) lane_q[b] <= wdata;
        end
        assign limit[b*BYTE_W +: BYTE_W] = lane_q[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            ien     <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (wrap_evt && !pending) flag <= 1'b1;
            else if (flag_clr)        flag <= 1'b0;
            if (stb.wr_ctrl)          ien  <= cw.irq_en;
            if (stb.wr_mod_hi)        pending <= 1'b1;
            else if (stb.wr_mod_lo)   pending <= 1'b0;
        end
    end

    assign irq = flag && ien && !pending;

    p_pending_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (pending && !flag) |=> !flag);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    p_flag_cleared_r10: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !wrap_evt) |=> !flag);

    p_limit_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (!stb.wr_mod_hi && !stb.wr_mod_lo) |=> $stable(limit));
endmodule

// File: rtl/bmt_top.sv
module bmt_top
    import bmt_pkg::*;
#(
    parameter addr_t CTRL_ADDR   = 8'h20,
    parameter addr_t CNT_HI_ADDR = 8'h21,
    parameter addr_t CNT_LO_ADDR = 8'h22,
    parameter addr_t MOD_HI_ADDR = 8'h23,
    parameter addr_t MOD_LO_ADDR = 8'h24,
    parameter cnt_t  LIMIT_RST   = '1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        freeze,
    input  logic [7:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        ovf_irq
);
    reg_sel_e sel;
    strobe_t  stb;
    cnt_t     count;
    cnt_t     limit;
    logic     wrap_evt;
    logic     flag;
    logic     ien;
    logic     pending;
    logic     cnt_clr;
    byte_t    lo_view;

    bmt_regdec #(
        .A_CTRL(CTRL_ADDR), .A_CNT_HI(CNT_HI_ADDR), .A_CNT_LO(CNT_LO_ADDR),
        .A_MOD_HI(MOD_HI_ADDR), .A_MOD_LO(MOD_LO_ADDR)
    ) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .sel(sel), .stb(stb)
    );

    bmt_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick_en), .freeze(freeze), .clr(cnt_clr),
        .limit(limit), .count(count), .wrap_evt(wrap_evt)
    );

    bmt_rdlatch u_lat (
        .clk(clk), .rst(rst), .rd_hi(stb.rd_cnt_hi), .rd_lo(stb.rd_cnt_lo),
        .live_lo(count[BYTE_W-1:0]), .lo_view(lo_view)
    );

    bmt_ovf #(.LIMIT_RST(LIMIT_RST)) u_ovf (
        .clk(clk), .rst(rst), .stb(stb), .wdata(bus_wdata), .wrap_evt(wrap_evt),
        .limit(limit), .flag(flag), .ien(ien), .pending(pending),
        .cnt_clr(cnt_clr), .irq(ovf_irq)
    );

    always_comb begin
        unique case (sel)
            SEL_CTRL:   bus_rdata = pack_status(flag, ien);
            SEL_CNT_HI: bus_rdata = count[CNT_W-1:BYTE_W];
            SEL_CNT_LO: bus_rdata = lo_view;
            SEL_MOD_HI: bus_rdata = limit[CNT_W-1:BYTE_W];
            SEL_MOD_LO: bus_rdata = limit[BYTE_W-1:0];
            default:    bus_rdata = '0;
        endcase
    end

    p_irq_quiet_pending_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> !ovf_irq);

    p_cnt_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == CNT_HI_ADDR || bus_addr == CNT_LO_ADDR)
         && !tick_en && !bus_rd) |=> $stable(count));
endmodule

// File: tb/tb_bmt_top.sv
module tb_bmt_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       freeze = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ovf_irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] m_cnt, m_lim;
    logic        m_flag, m_en, m_pend, m_held;
    logic [7:0]  m_snap;
    logic [7:0]  rv;
    logic [15:0] v16;

    always #4 clk = ~clk;

    bmt_top dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .freeze(freeze),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_irq(ovf_irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
        if (a == 8'h20) begin
            m_en = d[6];
            if (d[5]) m_cnt = 16'h0;
            if (!d[7]) m_flag = 1'b0;
        end else if (a == 8'h23) begin
            m_lim[15:8] = d; m_pend = 1'b1;
        end else if (a == 8'h24) begin
            m_lim[7:0] = d; m_pend = 1'b0;
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic m_tick();
        if (m_cnt == m_lim) begin
            m_cnt = 16'h0;
            if (!m_pend) m_flag = 1'b1;
        end else begin
            m_cnt = m_cnt + 16'h1;
        end
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            step();
            if (!freeze) m_tick();
        end
        tick_en = 1'b0;
    endtask

    // Expected upper/lower bytes come from the model, with latch effects applied.
    task automatic rd_hi(input string tag);
        rd(8'h21, rv);
        chk(tag, {8'h0, rv}, {8'h0, m_cnt[15:8]});
        if (!m_held) begin m_held = 1'b1; m_snap = m_cnt[7:0]; end
    endtask

    task automatic rd_lo(input string tag);
        rd(8'h22, rv);
        chk(tag, {8'h0, rv}, {8'h0, (m_held ? m_snap : m_cnt[7:0])});
        m_held = 1'b0;
    endtask

    task automatic rd_ctrl(input string tag);
        rd(8'h20, rv);
        chk(tag, {8'h0, rv}, {8'h0, m_flag, m_en, 6'b0});
    endtask

    task automatic chk_irq(input string tag);
        chk(tag, {15'h0, ovf_irq}, {15'h0, m_flag && m_en && !m_pend});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_cnt = 0; m_lim = 16'hFFFF; m_flag = 0; m_en = 0; m_pend = 0;
        m_held = 0; m_snap = 0;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk_irq("R1 irq");
        rd_ctrl("R1 ctrl");
        rd(8'h23, rv); chk("R1 limit hi", {8'h0, rv}, 16'h00FF);
        rd(8'h24, rv); chk("R1 limit lo", {8'h0, rv}, 16'h00FF);
        rd_hi("R1 count hi");
        rd_lo("R1 count lo");

        // R2 stepping, with idle gaps
        ticks(5);
        repeat (3) step();
        rd_hi("R2 hi"); rd_lo("R2 lo after 5 ticks");
        ticks(2); step(); ticks(1);
        rd_hi("R2 hi"); rd_lo("R2 lo after gaps");

        // R12 freeze
        freeze = 1'b1; ticks(4); freeze = 1'b0;
        rd_hi("R12 hi"); rd_lo("R12 lo frozen");

        // R9 clear bit zeroes the count, reads 0, limit intact
        wr(8'h20, 8'h20);
        rd_ctrl("R9 clear bit reads 0");
        rd_hi("R9 hi"); rd_lo("R9 lo cleared");
        rd(8'h24, rv); chk("R9 limit kept", {8'h0, rv}, 16'h00FF);

        // R3 / R10 sweep over small limits, two periods each
        for (int m = 0; m <= 12; m++) begin
            wr(8'h23, 8'h00);
            wr(8'h24, m[7:0]);
            wr(8'h20, 8'h20);
            for (int k = 0; k < 2 * m + 4; k++) begin
                ticks(1);
                rd_hi("R3 sweep hi");
                rd_lo("R3 sweep lo");
                rd_ctrl("R3 sweep flag");
                if (m_flag) begin
                    wr(8'h20, 8'h00);
                    rd_ctrl("R10 cleared by zero");
                end
            end
        end

        // R5 / R6 coherent read across a byte carry
        wr(8'h23, 8'hFF); wr(8'h24, 8'hFF); wr(8'h20, 8'h20);
        ticks(255);
        rd_hi("R5 hi before carry");
        ticks(1);
        rd_hi("R6 second hi read live");
        ticks(2);
        rd_lo("R5 lo returns captured byte");
        rd_lo("R4 lo live after release");

        // R7 writes to count bytes ignored, also while latched
        wr(8'h21, 8'h55); wr(8'h22, 8'hAA);
        rd_hi("R7 hi"); 
        wr(8'h22, 8'h11);
        rd_lo("R7 lo latched after write");
        rd_hi("R7 hi again"); rd_lo("R7 lo again");

        // R9 clear leaves captured byte alone
        ticks(3);
        rd_hi("R9 hi capture");
        wr(8'h20, 8'h20);
        rd_lo("R9 captured byte survives clear");
        rd_hi("R9 hi zero"); rd_lo("R9 lo zero");

        // R8 / R11 pending limit write
        wr(8'h23, 8'h00); wr(8'h24, 8'h03);
        wr(8'h20, 8'h60);
        wr(8'h20, 8'h40);
        wr(8'h23, 8'h00);
        ticks(4);
        rd_hi("R8 hi wrapped"); rd_lo("R8 lo wrapped");
        rd_ctrl("R8 flag held off");
        chk_irq("R8 irq quiet");
        wr(8'h24, 8'h03);
        ticks(4);
        rd_ctrl("R3 flag after release");
        chk_irq("R11 irq high");
        wr(8'h23, 8'h00);
        chk_irq("R11 irq gated by pending");
        rd_ctrl("R11 flag kept while pending");
        wr(8'h24, 8'h03);
        chk_irq("R11 irq back");
        wr(8'h20, 8'hC0);
        rd_ctrl("R10 write one keeps flag");
        wr(8'h20, 8'h80);
        chk_irq("R11 irq off when disabled");
        wr(8'h20, 8'h40);
        rd_ctrl("R10 cleared");
        chk_irq("R11 irq low after clear");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule